// File: doc/BRIEF.md
# Elastic Pipeline Register Stage

This block is a one-entry elastic register placed between a producer and a consumer that both use a ready/valid handshake. A word moves in on any clock edge where `valid_i` and `ready_o` are both high. It then stays on `data_o`, with `valid_o` high, until the consumer takes it with `ready_i`.

The upstream ready is a Mealy output. `ready_o` is high whenever the stage is empty, and also whenever the consumer takes the held word in the same cycle. A chain of these stages therefore moves one word per clock when both ends are ready. The cost is a combinational path from `ready_i` to `ready_o`.

Two elaboration-time parameters shape the data register:
- `CLEAR_DATA_ON_RESET` decides whether the synchronous reset zeroes the data register.
- `LOAD_ON_XFER_ONLY` decides when the register loads. When set, it loads only on an accepted transfer. When clear, it loads on every cycle in which the stage is ready, which saves an AND gate in the enable path but toggles the register more often.

Top module: `elastic_stage`

## Requirements
- R1: `ready_o` is high in the same cycle whenever `valid_o` is low or `ready_i` is high, and is low otherwise.
- R2: A clock edge with `reset_i` high leaves `valid_o` low, whatever the parameters.
- R3: Outside reset, an edge with `ready_o` high copies `valid_i` into `valid_o`.
- R4: Outside reset, an edge with `ready_o` low leaves `valid_o` and `data_o` unchanged.
- R5: Outside reset, an edge with `valid_i` and `ready_o` both high copies `data_i` into `data_o`.
- R6: When `CLEAR_DATA_ON_RESET` is 1, a reset edge sets `data_o` to 0, overriding any load. When it is 0, reset leaves the data register to the normal load rule.
- R7: When `LOAD_ON_XFER_ONLY` is 1, an edge with `ready_o` high and `valid_i` low leaves `data_o` unchanged.
- R8: When `LOAD_ON_XFER_ONLY` is 0, every edge with `ready_o` high copies `data_i` into `data_o`, even when `valid_i` is low.
- R9: While `valid_i` and `ready_i` are held high, `ready_o` stays high, so one word is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| reset_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Producer offers a word |
| ready_o | output | 1 | Stage can take a word this cycle |
| data_i | input | DATA_W | Word offered by the producer |
| valid_o | output | 1 | Stage holds a word for the consumer |
| ready_i | input | 1 | Consumer takes the held word this cycle |
| data_o | output | DATA_W | Held word |

## Verification
`ready_o` is combinational, so the bench reads it one time unit after driving the inputs, before the next rising edge.

`valid_o` and `data_o` each pass through exactly one register. Their new values are due just after the first rising edge that follows the stimulus, and the bench samples them one time unit after that edge.

The bench drives inputs on the falling edge and computes the expected post-edge values from the inputs it applied. Two instances run side by side:
- one with the defaults (clear on reset, load only on transfers);
- one with both options off.

This covers R6 through R8 in both settings.

// File: rtl/elastic_stage_pkg.sv
package elastic_stage_pkg;

    // Occupancy state of the single-entry stage
    typedef struct packed {
        logic full;
    } occ_t;

    // Decoded load/clear intent for the data register
    typedef struct packed {
        logic load;
        logic clear;
    } data_ctl_t;

endpackage

// File: rtl/elastic_stage_ctrl.sv
module elastic_stage_ctrl
    import elastic_stage_pkg::*;
(
    input  logic clk_i,
    input  logic reset_i,
    input  logic valid_i,
    input  logic ready_i,
    output logic ready_o,
    output logic valid_o,
    output logic accept_o
);

    occ_t occ_d, occ_q;
    logic open_w;

    // Mealy ready: room when empty or when the held word leaves now
    always_comb begin
        open_w   = ready_i | ~occ_q.full;
        accept_o = open_w & valid_i;
        occ_d    = occ_q;
        if (reset_i) begin
            occ_d.full = 1'b0;
        end else if (open_w) begin
            occ_d.full = valid_i;
        end
    end

    always_ff @(posedge clk_i) begin
        occ_q <= occ_d;
    end

    assign ready_o = open_w;
    assign valid_o = occ_q.full;

endmodule

// File: rtl/elastic_stage_dreg.sv
module elastic_stage_dreg
    import elastic_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter bit CLEAR_DATA_ON_RESET = 1'b1
) (
    input  logic              clk_i,
    input  data_ctl_t         ctl_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] word_d, word_q;

    generate
        if (CLEAR_DATA_ON_RESET) begin : g_clr
            always_comb begin
                word_d = word_q;
                if (ctl_i.clear) begin
                    word_d = '0;
                end else if (ctl_i.load) begin
                    word_d = data_i;
                end
            end
        end else begin : g_noclr
            always_comb begin
                word_d = word_q;
                if (ctl_i.load) begin
                    word_d = data_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        word_q <= word_d;
    end

    assign data_o = word_q;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
    import elastic_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter bit CLEAR_DATA_ON_RESET = 1'b1,
    parameter bit LOAD_ON_XFER_ONLY = 1'b1
) (
    input  logic              clk_i,
    input  logic              reset_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [DATA_W-1:0] data_o
);

    logic      accept_w;
    logic      open_w;
    data_ctl_t dctl_w;

    elastic_stage_ctrl i_ctrl (
        .clk_i    (clk_i),
        .reset_i  (reset_i),
        .valid_i  (valid_i),
        .ready_i  (ready_i),
        .ready_o  (open_w),
        .valid_o  (valid_o),
        .accept_o (accept_w)
    );

    generate
        if (LOAD_ON_XFER_ONLY) begin : g_gated
            always_comb begin
                dctl_w.load  = accept_w;
                dctl_w.clear = reset_i;
            end
        end else begin : g_open
            always_comb begin
                dctl_w.load  = open_w;
                dctl_w.clear = reset_i;
            end
        end
    endgenerate

    elastic_stage_dreg #(
        .DATA_W              (DATA_W),
        .CLEAR_DATA_ON_RESET (CLEAR_DATA_ON_RESET)
    ) i_dreg (
        .clk_i  (clk_i),
        .ctl_i  (dctl_w),
        .data_i (data_i),
        .data_o (data_o)
    );

    assign ready_o = open_w;

endmodule

// File: rtl/elastic_stage_chk.sv
module elastic_stage_chk #(
    parameter int DATA_W = 16,
    parameter bit CLEAR_DATA_ON_RESET = 1'b1,
    parameter bit LOAD_ON_XFER_ONLY = 1'b1
) (
    input logic              clk_i,
    input logic              reset_i,
    input logic              valid_i,
    input logic              ready_o,
    input logic [DATA_W-1:0] data_i,
    input logic              valid_o,
    input logic              ready_i,
    input logic [DATA_W-1:0] data_o
);

    // R1
    empty_ready_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        !valid_o |-> ready_o);

    // R1
    full_stall_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        (valid_o && !ready_i) |-> !ready_o);

    // R2
    reset_empties_chk: assert property (@(posedge clk_i)
        reset_i |=> !valid_o);

    // R3
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        ready_o |=> (valid_o == $past(valid_i)));

    // R4
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        !ready_o |=> ($stable(valid_o) && $stable(data_o)));

    // R5
    xfer_load_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        (valid_i && ready_o) |=> (data_o == $past(data_i)));

    // R9
    stream_ready_chk: assert property (@(posedge clk_i) disable iff (reset_i)
        (valid_i && ready_i) |-> ready_o);

    generate
        if (CLEAR_DATA_ON_RESET) begin : g_clr
            // R6
            reset_zero_chk: assert property (@(posedge clk_i)
                reset_i |=> (data_o == '0));
        end
        if (LOAD_ON_XFER_ONLY) begin : g_gate
            // R7
            idle_hold_chk: assert property (@(posedge clk_i) disable iff (reset_i)
                (ready_o && !valid_i) |=> $stable(data_o));
        end else begin : g_nogate
            // R8
            idle_load_chk: assert property (@(posedge clk_i) disable iff (reset_i)
                ready_o |=> (data_o == $past(data_i)));
        end
    endgenerate

endmodule

bind elastic_stage elastic_stage_chk #(
    .DATA_W              (DATA_W),
    .CLEAR_DATA_ON_RESET (CLEAR_DATA_ON_RESET),
    .LOAD_ON_XFER_ONLY   (LOAD_ON_XFER_ONLY)
) i_chk (
    .clk_i   (clk_i),
    .reset_i (reset_i),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .data_i  (data_i),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .data_o  (data_o)
);

// File: tb/test_elastic_stage.sv
module test_elastic_stage;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int N_RANDOM = 3000;

    logic         clk = 1'b0;
    logic         reset_i = 1'b1;
    logic         valid_i = 1'b0;
    logic         ready_i = 1'b0;
    logic [W-1:0] data_i = '0;

    logic         a_ready, a_valid, b_ready, b_valid;
    logic [W-1:0] a_data, b_data;

    int checks = 0;
    int fails  = 0;

    // model state
    logic         m_valid = 1'b0;
    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_b = '0;
    bit           b_known = 1'b0;
    bit           started = 1'b0;
    logic         last_rdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    // defaults: clear on reset, load only on transfers
    elastic_stage #(.DATA_W(W)) i_elastic_stage (
        .clk_i(clk), .reset_i(reset_i), .valid_i(valid_i), .ready_o(a_ready),
        .data_i(data_i), .valid_o(a_valid), .ready_i(ready_i), .data_o(a_data)
    );

    // both options off
    elastic_stage #(.DATA_W(W), .CLEAR_DATA_ON_RESET(1'b0), .LOAD_ON_XFER_ONLY(1'b0))
    i_elastic_stage_b (
        .clk_i(clk), .reset_i(reset_i), .valid_i(valid_i), .ready_o(b_ready),
        .data_i(data_i), .valid_o(b_valid), .ready_i(ready_i), .data_o(b_data)
    );

    function automatic logic exp_ready(logic held, logic rd);
        return rd | ~held;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(logic r, logic v, logic rd, logic [W-1:0] d);
        logic rdy, xfer;
        string tv, ta, tb;
        @(negedge clk);
        reset_i = r; valid_i = v; ready_i = rd; data_i = d;
        #1;
        rdy = exp_ready(m_valid, rd);
        last_rdy = a_ready;
        if (started) begin
            check("R1", "ready_o A", {{(W-1){1'b0}}, a_ready}, {{(W-1){1'b0}}, rdy});
            check("R1", "ready_o B", {{(W-1){1'b0}}, b_ready}, {{(W-1){1'b0}}, rdy});
        end
        xfer = v & rdy;
        // next model state
        if (r) begin
            tv = "R2";
            m_valid = 1'b0;
            ta = "R6"; m_a = '0;
            tb = "R6";
            if (rdy || !started) begin m_b = d; b_known = 1'b1; end
        end else begin
            tv = rdy ? "R3" : "R4";
            if (rdy) m_valid = v;
            ta = xfer ? "R5" : (rdy ? "R7" : "R4");
            if (xfer) m_a = d;
            tb = xfer ? "R5" : (rdy ? "R8" : "R4");
            if (rdy) begin m_b = d; b_known = 1'b1; end
        end
        @(posedge clk);
        #1;
        started = 1'b1;
        check(tv, "valid_o A", {{(W-1){1'b0}}, a_valid}, {{(W-1){1'b0}}, m_valid});
        check(tv, "valid_o B", {{(W-1){1'b0}}, b_valid}, {{(W-1){1'b0}}, m_valid});
        check(ta, "data_o A", a_data, m_a);
        if (b_known) check(tb, "data_o B", b_data, m_b);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        int xfers;
        seed = $urandom(32'h0000_5EED);
        // reset state, R2 and R6 (ready_i high so B loads during reset)
        step(1'b1, 1'b1, 1'b1, 16'hA5A5);
        step(1'b1, 1'b0, 1'b1, 16'h1234);
        // fill then stall: R4 holds valid and data
        step(1'b0, 1'b1, 1'b0, 16'hBEEF);
        step(1'b0, 1'b1, 1'b0, 16'h0F0F);
        step(1'b0, 1'b0, 1'b0, 16'h7777);
        // drain with no new word: R3 clears valid, R7/R8 on data
        step(1'b0, 1'b0, 1'b1, 16'hC0DE);
        step(1'b0, 1'b0, 1'b1, 16'hD00D);
        // R9: streaming, ready_o must stay high every cycle
        xfers = 0;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b1, 1'b1, W'(16'h1000 + i));
            if (last_rdy === 1'b1) xfers++;
        end
        check("R9", "accepted words in 16-cycle stream", W'(xfers), W'(16));
        // reset while holding a word: R2, R6
        step(1'b0, 1'b1, 1'b0, 16'h4444);
        step(1'b1, 1'b1, 1'b0, 16'h5555);
        step(1'b0, 1'b0, 1'b0, 16'h6666);
        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            step(($urandom % 40) == 0, ($urandom % 10) < 7,
                 ($urandom % 10) < 6, W'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule